// File: doc/BRIEF.md
# Set/Clear GPIO Bank

This block is a bank of general-purpose pins controlled from a simple memory-mapped register bus. Software never writes a whole direction or output word. It writes a mask to a register whose action is fixed, and only the pins whose mask bit is 1 are affected. One register raises the selected outputs and another lowers them. A write to either of these also turns the selected pins into outputs. A third register hands the selected pins back to input mode. Other pins keep their state, so two agents can share the bank without a read-modify-write sequence.

The input path is closed after reset. It opens the first time any value is written to the input-enable register. Pin levels pass through a two-flop synchronizer before they reach the pin-state register. A read of the pin-state register returns, for every pin, either its output latch (when it drives) or its synchronized input (when it listens).

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset every pin is in input mode (`pin_oe` = 0), every output latch is 0 (`pin_out` = 0), the input path is closed and `rdata` is 0.
- R2: A write to word address 0 (raise) sets `pin_out[n]` to 1 for each pin n whose `wdata[n]` is 1 and leaves every other latch unchanged.
- R3: A write to word address 1 (lower) sets `pin_out[n]` to 0 for each pin n whose `wdata[n]` is 1 and leaves every other latch unchanged.
- R4: A write to address 0 or 1 sets `pin_oe[n]` to 1 for each selected pin, and leaves the direction of unselected pins unchanged.
- R5: A write to word address 2 (release) sets `pin_oe[n]` to 0 for each selected pin and leaves every output latch unchanged.
- R6: A read of word address 3 (pin state) returns in bit n the output latch when pin n drives, else its input after two synchronizer flops. A change on `pin_in` first shows up in a read that is sampled on the third rising edge after the change.
- R7: Input-mode pins read 0 until the first write to word address 4 (input enable). Any data value, including 0, opens the input path, and it stays open until reset.
- R8: Reads of addresses 0, 1, 2 and 4 to 7 return 0.
- R9: A write takes effect on the rising edge at which `wr_en` is sampled high. `rdata` is registered: it is valid one cycle after a read strobe, and it is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W (3) | Word address of the register |
| wdata | input | PINS (32) | Write data; bit n is the mask bit for pin n |
| rdata | output | PINS (32) | Registered read data |
| pin_in | input | PINS (32) | Asynchronous pin levels from the pads |
| pin_out | output | PINS (32) | Output latch value per pin |
| pin_oe | output | PINS (32) | Output driver enable per pin, 1 = drives |

## Verification
On every cycle the assertions check the mask actions of raise, lower and release (R2 to R5). They also check that outputs and directions are stable in cycles with no write, that the input gate never closes once opened, and that non-state reads return 0. The synchronizer latency and the closed input path before enable (R6, R7) show only in the bench's scenarios. Those scenarios change `pin_in` around back-to-back reads and reset the bank a second time. A behavioural model compares `pin_out`, `pin_oe` and `rdata` on every clock.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    REG_RAISE   = 3'd0,
    REG_LOWER   = 3'd1,
    REG_RELEASE = 3'd2,
    REG_STATE   = 3'd3,
    REG_INOPEN  = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic raise;
    logic lower;
    logic release_in;
    logic inopen;
    logic state_rd;
  } strobes_t;

  // Next value of an output latch: raise wins only because both can never
  // be decoded together; order kept explicit.
  function automatic logic next_level(input logic cur, input logic raise,
                                      input logic lower);
    if (raise)      return 1'b1;
    else if (lower) return 1'b0;
    else            return cur;
  endfunction

  // Next value of a direction bit: any drive write turns the pin around.
  function automatic logic next_dir(input logic cur, input logic drive,
                                    input logic release_in);
    if (drive)           return 1'b1;
    else if (release_in) return 1'b0;
    else                 return cur;
  endfunction

  // Level reported for one pin in the state register.
  function automatic logic seen_level(input logic oe, input logic latch,
                                      input logic synced, input logic open_in);
    if (oe) return latch;
    return synced & open_in;
  endfunction

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          strobes
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_sel_e sel);
    return a == ADDR_W'(sel);
  endfunction

  always_comb begin
    strobes.raise      = wr_en & hit(addr, REG_RAISE);
    strobes.lower      = wr_en & hit(addr, REG_LOWER);
    strobes.release_in = wr_en & hit(addr, REG_RELEASE);
    strobes.inopen     = wr_en & hit(addr, REG_INOPEN);
    strobes.state_rd   = rd_en & hit(addr, REG_STATE);
  end

endmodule

// File: rtl/gpio_input_gate.sv
module gpio_input_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic open_strobe,
  output logic open_in
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          open_in <= 1'b0;
    else if (open_strobe) open_in <= 1'b1;
  end

endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_bank_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raise_hit,
  input  logic lower_hit,
  input  logic release_hit,
  input  logic pad_level,
  input  logic open_in,
  output logic latch_q,
  output logic oe_q,
  output logic level
);

  logic [SYNC_STAGES-1:0] sync_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_sh <= '0;
    else        sync_sh <= {sync_sh[SYNC_STAGES-2:0], pad_level};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      latch_q <= next_level(latch_q, raise_hit, lower_hit);
      oe_q    <= next_dir(oe_q, raise_hit | lower_hit, release_hit);
    end
  end

  assign level = seen_level(oe_q, latch_q, sync_sh[SYNC_STAGES-1], open_in);

endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PINS        = 32,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   wdata,
  output logic [PINS-1:0]   rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe
);

  strobes_t        strobes;
  logic            in_open_w;
  logic [PINS-1:0] state_vec;
  logic [PINS-1:0] rdata_q;

  gpio_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .strobes (strobes)
  );

  gpio_input_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .open_strobe (strobes.inopen),
    .open_in     (in_open_w)
  );

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    gpio_pin_slice #(.SYNC_STAGES(SYNC_STAGES)) u_slice (
      .clk         (clk),
      .rst_n       (rst_n),
      .raise_hit   (strobes.raise & wdata[n]),
      .lower_hit   (strobes.lower & wdata[n]),
      .release_hit (strobes.release_in & wdata[n]),
      .pad_level   (pin_in[n]),
      .open_in     (in_open_w),
      .latch_q     (pin_out[n]),
      .oe_q        (pin_oe[n]),
      .level       (state_vec[n])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rdata_q <= '0;
    else if (strobes.state_rd) rdata_q <= state_vec;
    else                       rdata_q <= '0;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/gpio_setclr_bank_chk.sv
module gpio_setclr_bank_chk #(
  parameter int unsigned PINS   = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [PINS-1:0]   wdata,
  input logic [PINS-1:0]   rdata,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe,
  input logic              in_open_w
);

  logic is_raise, is_lower, is_release;
  assign is_raise   = wr_en && (addr == ADDR_W'(0));
  assign is_lower   = wr_en && (addr == ADDR_W'(1));
  assign is_release = wr_en && (addr == ADDR_W'(2));

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && rdata == '0));

  a_r2_raise_mask: assert property (@(posedge clk) disable iff (!rst_n)
    is_raise |=> ((pin_out & $past(wdata)) == $past(wdata))
                 && ((pin_out & ~$past(wdata)) == ($past(pin_out) & ~$past(wdata))));

  a_r3_lower_mask: assert property (@(posedge clk) disable iff (!rst_n)
    is_lower |=> ((pin_out & $past(wdata)) == '0)
                 && ((pin_out & ~$past(wdata)) == ($past(pin_out) & ~$past(wdata))));

  a_r4_drive_turns_out: assert property (@(posedge clk) disable iff (!rst_n)
    (is_raise || is_lower) |=> ((pin_oe & $past(wdata)) == $past(wdata))
                 && ((pin_oe & ~$past(wdata)) == ($past(pin_oe) & ~$past(wdata))));

  a_r5_release_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
    is_release |=> ((pin_oe & $past(wdata)) == '0) && $stable(pin_out));

  a_r7_gate_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    in_open_w |=> in_open_w);

  a_r8_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != ADDR_W'(3)) |=> (rdata == '0));

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pin_out) && $stable(pin_oe)));

  a_r9_no_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0));

endmodule

bind gpio_setclr_bank gpio_setclr_bank_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .in_open_w (in_open_w)
);

// File: tb/tb_gpio_setclr_bank.sv
`timescale 1ns/1ps
module tb_gpio_setclr_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_setclr_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe)
  );

  // Behavioural reference model
  logic [31:0] m_out, m_oe, m_s1, m_s2, m_rd;
  bit          m_open;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out <= 0; m_oe <= 0; m_s1 <= 0; m_s2 <= 0; m_rd <= 0; m_open <= 0;
    end else begin
      m_s1 <= pin_in;
      m_s2 <= m_s1;
      if (wr_en) begin
        case (addr)
          3'd0: begin m_out <= m_out | wdata;  m_oe <= m_oe | wdata; end
          3'd1: begin m_out <= m_out & ~wdata; m_oe <= m_oe | wdata; end
          3'd2: m_oe <= m_oe & ~wdata;
          3'd4: m_open <= 1;
          default: ;
        endcase
      end
      if (rd_en && addr == 3'd3) begin
        logic [31:0] v;
        v = 0;
        for (int i = 0; i < 32; i++)
          v[i] = m_oe[i] ? m_out[i] : (m_open ? m_s2[i] : 1'b0);
        m_rd <= v;
      end else begin
        m_rd <= 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 model pin_out", pin_out, m_out);
      chk("R4 model pin_oe", pin_oe, m_oe);
      chk("R6 model rdata", rdata, m_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; wdata = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    chk(req, rdata, exp);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    pin_in = 32'hA5C3_3C5A;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 pin_out", pin_out, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 rdata", rdata, 0);
    repeat (3) @(negedge clk);
    rd(3'd3, 32'h0, "R7 closed input reads zero");

    // R9: no effect before the edge, effect right after it
    @(negedge clk);
    wr_en = 1; addr = 3'd0; wdata = 32'h0000_00FF;
    #1 chk("R9 before edge", pin_out, 0);
    @(negedge clk);
    wr_en = 0; wdata = 0;
    chk("R2 raise", pin_out, 32'h0000_00FF);
    chk("R4 raise drives", pin_oe, 32'h0000_00FF);
    rd(3'd3, 32'h0000_00FF, "R6 outputs read latch, inputs closed");

    wr(3'd4, 32'h0);
    repeat (3) @(negedge clk);
    rd(3'd3, 32'hA5C3_3CFF, "R7 enable with zero data");

    wr(3'd1, 32'h0000_000F);
    chk("R3 lower", pin_out, 32'h0000_00F0);
    wr(3'd1, 32'h0F00_0000);
    chk("R3 lower unset bits", pin_out, 32'h0000_00F0);
    chk("R4 lower drives", pin_oe, 32'h0F00_00FF);
    wr(3'd0, 32'hF000_0000);
    chk("R2 raise keeps others", pin_out, 32'hF000_00F0);
    wr(3'd2, 32'h0F00_00F0);
    chk("R5 release dir", pin_oe, 32'hF000_000F);
    chk("R5 release keeps latch", pin_out, 32'hF000_00F0);
    rd(3'd3, 32'hF5C3_3C50, "R6 mixed state");

    // R6 synchronizer latency with back-to-back reads
    @(negedge clk);
    pin_in = 32'h5A3C_C3A5; rd_en = 1; addr = 3'd3;
    @(negedge clk);
    chk("R6 old value edge 1", rdata, 32'hF5C3_3C50);
    @(negedge clk);
    chk("R6 old value edge 2", rdata, 32'hF5C3_3C50);
    @(negedge clk);
    rd_en = 0;
    chk("R6 new value edge 3", rdata, 32'hFA3C_C3A0);
    @(negedge clk);
    chk("R9 rdata zero after read", rdata, 0);

    for (int a = 0; a < 8; a++)
      if (a != 3) rd(3'(a), 32'h0, "R8 non-state read");

    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd3, 32'hFA3C_C3A0, "R7 gate stays open");

    // second reset closes the input path again
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk("R1 reset pin_oe", pin_oe, 0);
    chk("R1 reset pin_out", pin_out, 0);
    repeat (3) @(negedge clk);
    rd(3'd3, 32'h0, "R1 R7 closed after reset");

    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

endmodule